// File: doc/BRIEF.md
# DDR2 Read Latency Scheduler

This block sits on the controller side of a DDR2-style memory interface. It follows every READ command the controller issues and tells the read datapath which clock cycles carry that command's data. The programmed read latency is the sum of two parts. The first is a CAS latency taken from a three-bit field of the mode-register word. The second is a posted additive latency supplied alongside it. Both are captured on a mode-register load strobe.

For every accepted READ the block raises a data-valid strobe for the two clock cycles that hold the four double-data-rate beats of the burst. It also presents the index of the first beat carried in each of those cycles. A latency code the memory does not support is refused, as is an additive latency outside the supported range. A load that arrives while a read is still pending is refused as well. In each of these cases a configuration error flag is raised and the previous latency stays in force.

Top module: `rd_lat_sched`

## Requirements
- R1: After reset the block has no pending reads, `rd_valid` and `cfg_err` are 0, and the active latency is CAS latency 3 with additive latency 0.
- R2: On an accepted load the CAS latency is taken from bits [6:4] of `mr_word` as a plain binary number (3'b011 gives 3, 3'b111 gives 7). All other bits of the word have no effect.
- R3: Codes 0, 1 and 2 in bits [6:4] are reserved. Loading one sets `cfg_err` to 1 and leaves the active latency unchanged.
- R4: `al_cfg` is captured as the additive latency on an accepted load and may be 0 to 4. A load with `al_cfg` of 5 or more sets `cfg_err` and leaves the active latency unchanged.
- R5: A READ sampled at clock edge n gives first data at edge n+AL+CL. `rd_valid` goes to 1 on that edge and holds for the cycle that follows it.
- R6: Each burst of four beats occupies exactly two consecutive valid cycles. `rd_beat` is 0 in the first cycle (beats 0 and 1) and 2 in the second (beats 2 and 3).
- R7: READs issued two cycles apart give valid windows that touch with no gap, so `rd_valid` stays high without a break.
- R8: A READ in the cycle directly after an accepted READ is ignored and produces no data window.
- R9: A load is refused whenever a read is pending or `rd_cmd` is high in the same cycle. In that case `cfg_err` is set and the latency is kept. Once the last window has ended, a load is accepted again.
- R10: An accepted load clears `cfg_err`. Without a load, `cfg_err` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mr_load | input | 1 | Mode-register load strobe |
| mr_word | input | 13 | Mode-register word; bits [6:4] hold the CAS latency |
| al_cfg | input | 3 | Additive latency captured on load |
| rd_cmd | input | 1 | READ command strobe |
| rd_valid | output | 1 | Read data present in this cycle |
| rd_beat | output | 2 | Index of the first beat carried in this cycle (0 or 2) |
| cfg_err | output | 1 | Last load was refused |

## Verification
Some properties are checked by assertions on every cycle. A refused load must set the error flag and keep the latency, whether the cause is a reserved code, an oversized additive latency or a pending read. An accepted load must install exactly the decoded sum and clear the flag. Every first-half window cycle must be followed by its second half, and valid must never appear while nothing is pending. The exact edge on which data lands for each latency, the gap-free joining of READs two cycles apart, and the dropping of a READ right after another depend on the history of commands. These are shown by the bench scenarios, which compare every cycle against a queue-based model.

// File: rtl/rls_pkg.sv
package rls_pkg;
    localparam int CODE_W = 3;
    localparam int MIN_CL = 3;

    typedef struct packed {
        logic [CODE_W-1:0] cl;
        logic [CODE_W-1:0] al;
        logic              err;
    } cfg_t;

    function automatic logic cl_code_ok(input logic [CODE_W-1:0] code);
        return int'(code) >= MIN_CL;
    endfunction
endpackage

// File: rtl/rls_cfg.sv
module rls_cfg
    import rls_pkg::*;
#(
    parameter int MR_W   = 13,
    parameter int CL_LSB = 4,
    parameter int MAX_AL = 4,
    parameter int LAT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MR_W-1:0]  word,
    input  logic [2:0]       al_in,
    input  logic             busy,
    output logic [LAT_W-1:0] lat,
    output logic             err
);
    cfg_t cfg_d, cfg_q;
    logic [CODE_W-1:0] code;

    assign code = word[CL_LSB +: CODE_W];

    logic unused_bits;
    assign unused_bits = ^{word[MR_W-1:CL_LSB+CODE_W], word[CL_LSB-1:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            if (busy) begin
                cfg_d.err = 1'b1;
            end else if (!cl_code_ok(code) || (int'(al_in) > MAX_AL)) begin
                cfg_d.err = 1'b1;
            end else begin
                cfg_d.cl  = code;
                cfg_d.al  = al_in;
                cfg_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.cl  <= CODE_W'(MIN_CL);
            cfg_q.al  <= '0;
            cfg_q.err <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lat = LAT_W'(cfg_q.cl) + LAT_W'(cfg_q.al);
    assign err = cfg_q.err;
endmodule

// File: rtl/rls_pipe.sv
module rls_pipe #(
    parameter int DEPTH = 13,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic [LAT_W-1:0] lat,
    output logic [DEPTH-1:0] stg,
    output logic             busy
);
    typedef struct packed {
        logic [DEPTH-1:0] tok;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        // a read one cycle after an accepted read is dropped
        pipe_d.tok[0] = rd_cmd & ~pipe_q.tok[0];
        for (int k = 1; k < DEPTH; k++) begin
            if (k <= int'(lat) + 1) begin
                pipe_d.tok[k] = pipe_q.tok[k-1];
            end else begin
                pipe_d.tok[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q.tok <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign stg  = pipe_q.tok;
    assign busy = |pipe_q.tok;
endmodule

// File: rtl/rls_tap.sv
module rls_tap #(
    parameter int DEPTH = 13,
    parameter int LAT_W = 4
) (
    input  logic [DEPTH-1:0] stg,
    input  logic [LAT_W-1:0] lat,
    output logic             valid,
    output logic [1:0]       beat
);
    logic [LAT_W-1:0] lat_nx;
    logic             first_half;
    logic             second_half;

    assign lat_nx = lat + LAT_W'(1);

    always_comb begin
        first_half  = stg[lat];
        second_half = stg[lat_nx];
        valid       = first_half | second_half;
        beat        = second_half ? 2'd2 : 2'd0;
    end
endmodule

// File: rtl/rd_lat_sched.sv
module rd_lat_sched #(
    parameter int MR_W   = 13,
    parameter int CL_LSB = 4,
    parameter int MAX_CL = 7,
    parameter int MAX_AL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mr_load,
    input  logic [MR_W-1:0] mr_word,
    input  logic [2:0]      al_cfg,
    input  logic            rd_cmd,
    output logic            rd_valid,
    output logic [1:0]      rd_beat,
    output logic            cfg_err
);
    localparam int DEPTH = MAX_AL + MAX_CL + 2;
    localparam int LAT_W = $clog2(DEPTH);

    logic [LAT_W-1:0] lat_tot;
    logic [DEPTH-1:0] stg;
    logic             pend;
    logic             cfg_busy;

    assign cfg_busy = pend | rd_cmd;

    rls_cfg #(
        .MR_W  (MR_W),
        .CL_LSB(CL_LSB),
        .MAX_AL(MAX_AL),
        .LAT_W (LAT_W)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mr_load),
        .word (mr_word),
        .al_in(al_cfg),
        .busy (cfg_busy),
        .lat  (lat_tot),
        .err  (cfg_err)
    );

    rls_pipe #(
        .DEPTH(DEPTH),
        .LAT_W(LAT_W)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_cmd(rd_cmd),
        .lat   (lat_tot),
        .stg   (stg),
        .busy  (pend)
    );

    rls_tap #(
        .DEPTH(DEPTH),
        .LAT_W(LAT_W)
    ) u_tap (
        .stg  (stg),
        .lat  (lat_tot),
        .valid(rd_valid),
        .beat (rd_beat)
    );
endmodule

// File: rtl/rls_chk.sv
module rls_chk #(
    parameter int MR_W   = 13,
    parameter int CL_LSB = 4,
    parameter int MAX_AL = 4,
    parameter int LAT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mr_load,
    input logic [MR_W-1:0]  mr_word,
    input logic [2:0]       al_cfg,
    input logic             rd_cmd,
    input logic             rd_valid,
    input logic [1:0]       rd_beat,
    input logic             cfg_err,
    input logic             pend,
    input logic [LAT_W-1:0] lat
);
    logic [2:0] code;
    logic       bad_code;
    logic       bad_al;
    logic       blocked;

    assign code     = mr_word[CL_LSB +: 3];
    assign bad_code = code < 3'd3;
    assign bad_al   = int'(al_cfg) > MAX_AL;
    assign blocked  = pend | rd_cmd;

    AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mr_load && bad_code |=> cfg_err && $stable(lat)); // R3
    AST_AL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mr_load && bad_al |=> cfg_err && $stable(lat)); // R4
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mr_load && blocked |=> cfg_err && $stable(lat)); // R9
    AST_GOOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mr_load && !blocked && !bad_code && !bad_al
        |=> !cfg_err && (lat == LAT_W'($past(code)) + LAT_W'($past(al_cfg)))); // R2
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_load |=> $stable(cfg_err)); // R10
    AST_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_beat == 2'd0 |=> rd_valid && rd_beat == 2'd2); // R6
    AST_BEAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_beat == 2'd0 || rd_beat == 2'd2); // R6
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> !rd_valid); // R5
endmodule

bind rd_lat_sched rls_chk #(
    .MR_W  (MR_W),
    .CL_LSB(CL_LSB),
    .MAX_AL(MAX_AL),
    .LAT_W (LAT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mr_load (mr_load),
    .mr_word (mr_word),
    .al_cfg  (al_cfg),
    .rd_cmd  (rd_cmd),
    .rd_valid(rd_valid),
    .rd_beat (rd_beat),
    .cfg_err (cfg_err),
    .pend    (pend),
    .lat     (lat_tot)
);

// File: tb/sim_rd_lat_sched.sv
module sim_rd_lat_sched;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mr_load = 1'b0;
    logic [12:0] mr_word = '0;
    logic [2:0]  al_cfg = '0;
    logic        rd_cmd = 1'b0;
    logic        rd_valid;
    logic [1:0]  rd_beat;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    int acc_t[$];
    int acc_l[$];
    int now = 0;
    int cl_m = 3;
    int al_m = 0;
    int last_acc = -100;
    bit err_m = 0;
    bit exp_v = 0;
    int exp_b = 0;

    int vcount = 0;
    int vrises = 0;
    bit prev_v = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_lat_sched u0 (
        .clk(clk), .rst_n(rst_n), .mr_load(mr_load), .mr_word(mr_word),
        .al_cfg(al_cfg), .rd_cmd(rd_cmd), .rd_valid(rd_valid),
        .rd_beat(rd_beat), .cfg_err(cfg_err)
    );

    function automatic logic [12:0] mk(input int code);
        return (13'h1A0F & ~13'h0070) | 13'((code & 7) << 4);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic model_edge();
        bit busy_m;
        int code;
        now++;
        busy_m = rd_cmd;
        foreach (acc_t[i])
            if (acc_t[i] + acc_l[i] + 1 >= now - 1) busy_m = 1;
        if (rd_cmd && last_acc != now - 1) begin
            acc_t.push_back(now);
            acc_l.push_back(cl_m + al_m);
            last_acc = now;
        end
        if (mr_load) begin
            code = int'(mr_word[6:4]);
            if (busy_m || code < 3 || int'(al_cfg) > 4) err_m = 1;
            else begin
                cl_m = code; al_m = int'(al_cfg); err_m = 0;
            end
        end
        exp_v = 0; exp_b = 0;
        foreach (acc_t[i]) begin
            if (now == acc_t[i] + acc_l[i]) exp_v = 1;
            if (now == acc_t[i] + acc_l[i] + 1) begin exp_v = 1; exp_b = 2; end
        end
        while (acc_t.size() > 0 && acc_t[0] + acc_l[0] + 2 < now) begin
            void'(acc_t.pop_front());
            void'(acc_l.pop_front());
        end
    endtask

    task automatic cyc(input bit cmd, input bit ld, input logic [12:0] w, input int a);
        rd_cmd = cmd; mr_load = ld; mr_word = w; al_cfg = 3'(a);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rd_cmd = 0; mr_load = 0;
        check(rd_valid == exp_v, tag, "model rd_valid", int'(rd_valid), int'(exp_v));
        if (exp_v)
            check(int'(rd_beat) == exp_b, tag, "model rd_beat", int'(rd_beat), exp_b);
        check(cfg_err == err_m, tag, "model cfg_err", int'(cfg_err), int'(err_m));
        if (rd_valid) vcount++;
        if (rd_valid && !prev_v) vrises++;
        prev_v = rd_valid;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 0);
    endtask

    task automatic load(input int code, input int a);
        cyc(0, 1, mk(code), a);
    endtask

    task automatic measure(input int expl, input string req);
        int j = 0;
        cyc(1, 0, '0, 0);
        while (!rd_valid && j < 20) begin
            idle(1);
            j++;
        end
        check(j == expl, req, "first data cycle", j, expl);
        check(rd_beat == 2'd0, req, "first half beat", int'(rd_beat), 0);
        idle(1);
        check(rd_valid && rd_beat == 2'd2, req, "second half", int'(rd_beat), 2);
        idle(1);
        check(!rd_valid, req, "window ends", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 0, "R1", "reset rd_valid", int'(rd_valid), 0);
        check(cfg_err == 0, "R1", "reset cfg_err", int'(cfg_err), 0);
        rst_n = 1;
        tag = "R1"; measure(3, "R1");

        tag = "R5"; load(5, 0);
        check(cfg_err == 0, "R10", "good load flag", int'(cfg_err), 0);
        measure(5, "R5");
        load(7, 4); measure(11, "R5");
        tag = "R2"; load(4, 2); measure(6, "R2");

        tag = "R3"; load(2, 0);
        check(cfg_err == 1, "R3", "reserved code 2 flag", int'(cfg_err), 1);
        measure(6, "R3");
        load(0, 0);
        check(cfg_err == 1, "R3", "reserved code 0 flag", int'(cfg_err), 1);
        measure(6, "R3");

        tag = "R10"; load(3, 1);
        check(cfg_err == 0, "R10", "flag cleared", int'(cfg_err), 0);
        idle(2);
        check(cfg_err == 0, "R10", "flag held", int'(cfg_err), 0);
        measure(4, "R10");

        tag = "R4"; load(7, 5);
        check(cfg_err == 1, "R4", "al too large flag", int'(cfg_err), 1);
        measure(4, "R4");
        load(6, 0);

        tag = "R7"; load(4, 0);
        vcount = 0; vrises = 0;
        cyc(1, 0, '0, 0); idle(1); cyc(1, 0, '0, 0); idle(1); cyc(1, 0, '0, 0);
        idle(14);
        check(vcount == 6, "R7", "valid cycles", vcount, 6);
        check(vrises == 1, "R7", "valid runs", vrises, 1);

        tag = "R8"; vcount = 0; vrises = 0;
        cyc(1, 0, '0, 0); cyc(1, 0, '0, 0);
        idle(10);
        check(vcount == 2, "R8", "valid cycles", vcount, 2);
        check(vrises == 1, "R8", "valid runs", vrises, 1);

        tag = "R9";
        cyc(1, 0, '0, 0);
        load(6, 0);
        check(cfg_err == 1, "R9", "load while pending", int'(cfg_err), 1);
        idle(8);
        cyc(1, 1, mk(7), 0);
        check(cfg_err == 1, "R9", "load with read", int'(cfg_err), 1);
        idle(8);
        measure(4, "R9");
        load(5, 1);
        check(cfg_err == 0, "R9", "load after drain", int'(cfg_err), 0);
        measure(6, "R9");

        tag = "R6"; load(3, 0);
        measure(3, "R6");
        idle(3);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule